// File: doc/BRIEF.md
# Mixed-Length Instruction Boundary Splitter

This block takes a fetch group of code in which 16-bit and 32-bit instructions are freely interleaved and cuts it into individual instructions. The group is viewed as a row of 32-bit chunks. Each chunk is handled by one identical slice. A slice sees its own chunk together with the upper 16-bit parcel of the chunk below it. From this 48-bit window it produces up to two instruction slots. The only thing passed from one slice to the next is a single bit that says whether the neighbour's upper parcel opens a 32-bit instruction.

That bit leaves the last slice and goes into a register. The register also keeps the group's top parcel, so a 32-bit instruction whose lower half closes one group and whose upper half opens the next is still emitted whole. The slot for it belongs to the first slice of the later group. A fetch unit feeds the block one group per cycle under a valid strobe, and pulses a flush on any redirect. Downstream logic reads the slots in program order, using their valid and size flags.

Top module: `mixlen_splitter`

## Requirements
- R1: A 16-bit parcel opens a 32-bit instruction when its bits [1:0] equal 2'b11; any other value is a whole 16-bit instruction. A 16-bit slot carries the parcel in insn[15:0] with insn[31:16] zero, and its size flag is 0. A 32-bit slot has its size flag set to 1.
- R2: Chunk k sits at grp_data_i[32k+31:32k], with its lower-addressed parcel in bits [15:0]. When the chunk holds two 16-bit instructions, slot 2k carries the lower one and slot 2k+1 the upper one. Both slots are valid.
- R3: When no instruction is pending from below and the lower parcel of chunk k opens a 32-bit instruction, slot 2k carries the whole chunk as a 32-bit instruction and slot 2k+1 is invalid.
- R4: When a 32-bit instruction is pending from below, slot 2k carries {lower parcel of chunk k, pending parcel} as one 32-bit instruction. If the upper parcel of chunk k is 16-bit, slot 2k+1 carries it.
- R5: When a pending 32-bit instruction is completed and the upper parcel of chunk k opens another, slot 2k+1 is invalid. The new instruction is emitted by slice k+1.
- R6: If the top parcel of an accepted group opens a 32-bit instruction, that parcel is held. The next accepted group then emits slot 0 as a 32-bit instruction whose low half is the held parcel.
- R7: While grp_valid_i is low, every slot is invalid and the held parcel and pending state are kept unchanged.
- R8: In a cycle with flush_i high, every slot is invalid and the group is discarded. The pending state is cleared, so the next group starts with no pending instruction.
- R9: Reset clears the pending state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grp_valid_i | input | 1 | A fetch group is present and is accepted this cycle |
| flush_i | input | 1 | Redirect: discards the group and clears the pending state |
| grp_data_i | input | 32*SLICES | Fetch group; chunk k in bits [32k+31:32k] |
| slot_valid_o | output | 2*SLICES | Per-slot valid, in program order |
| slot_is32_o | output | 2*SLICES | Per-slot size flag, 1 for a 32-bit instruction |
| slot_insn_o | output | 64*SLICES | Slot j instruction in bits [32j+31:32j] |

## Verification
The bench targets the chained cases. In these a 32-bit instruction straddles two slices, or straddles two groups with idle cycles in between. A design with a broken carry would drop the upper parcel, or emit it as a bogus 16-bit slot. One that swapped the parcel order would emit a 32-bit word with its halves reversed. Flushes and resets are applied while a parcel is pending. A design that failed to clear it would glue a stale parcel onto the first instruction after the redirect.

// File: rtl/mixlen_pkg.sv
package mixlen_pkg;

  localparam int PARCEL_W = 16;
  localparam int WORD_W   = 32;

  typedef struct packed {
    logic              vld;
    logic              is32;
    logic [WORD_W-1:0] insn;
  } slot_t;

  function automatic logic opens_wide(input logic [PARCEL_W-1:0] p);
    return p[1:0] == 2'b11;
  endfunction

endpackage

// File: rtl/mixlen_slice.sv
module mixlen_slice
  import mixlen_pkg::*;
(
  input  logic                en,
  input  logic                carry_in,
  input  logic [PARCEL_W-1:0] prev_hi,
  input  logic [WORD_W-1:0]   chunk,
  output slot_t               slot_lo,
  output slot_t               slot_hi,
  output logic                carry_out
);

  logic [PARCEL_W-1:0] lo_p;
  logic [PARCEL_W-1:0] hi_p;

  assign lo_p = chunk[PARCEL_W-1:0];
  assign hi_p = chunk[WORD_W-1:PARCEL_W];

  always_comb begin
    slot_lo   = '0;
    slot_hi   = '0;
    carry_out = 1'b0;
    if (carry_in) begin
      slot_lo.vld  = en;
      slot_lo.is32 = 1'b1;
      slot_lo.insn = {lo_p, prev_hi};
      if (opens_wide(hi_p)) begin
        carry_out = 1'b1;
      end else begin
        slot_hi.vld  = en;
        slot_hi.insn = {{PARCEL_W{1'b0}}, hi_p};
      end
    end else if (opens_wide(lo_p)) begin
      slot_lo.vld  = en;
      slot_lo.is32 = 1'b1;
      slot_lo.insn = chunk;
    end else begin
      slot_lo.vld  = en;
      slot_lo.insn = {{PARCEL_W{1'b0}}, lo_p};
      if (opens_wide(hi_p)) begin
        carry_out = 1'b1;
      end else begin
        slot_hi.vld  = en;
        slot_hi.insn = {{PARCEL_W{1'b0}}, hi_p};
      end
    end
  end

endmodule

// File: rtl/mixlen_carry_reg.sv
module mixlen_carry_reg
  import mixlen_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                accept,
  input  logic                flush,
  input  logic                carry_d,
  input  logic [PARCEL_W-1:0] hi_d,
  output logic                carry_q,
  output logic [PARCEL_W-1:0] hi_q
);

  logic                carry_nx;
  logic [PARCEL_W-1:0] hi_nx;
  logic                load_en;

  assign load_en = accept | flush;

  always_comb begin
    carry_nx = carry_q;
    hi_nx    = hi_q;
    if (flush) begin
      carry_nx = 1'b0;
      hi_nx    = '0;
    end else if (accept) begin
      carry_nx = carry_d;
      hi_nx    = hi_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carry_q <= 1'b0;
      hi_q    <= '0;
    end else if (load_en) begin
      carry_q <= carry_nx;
      hi_q    <= hi_nx;
    end
  end

endmodule

// File: rtl/mixlen_splitter.sv
module mixlen_splitter
  import mixlen_pkg::*;
#(
  parameter int SLICES = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   grp_valid_i,
  input  logic                   flush_i,
  input  logic [32*SLICES-1:0]   grp_data_i,
  output logic [2*SLICES-1:0]    slot_valid_o,
  output logic [2*SLICES-1:0]    slot_is32_o,
  output logic [64*SLICES-1:0]   slot_insn_o
);

  localparam int GRP_W = WORD_W * SLICES;

  logic                accept;
  logic [SLICES:0]     cy;
  logic                carry_q;
  logic [PARCEL_W-1:0] hi_q;

  assign accept = grp_valid_i & ~flush_i;
  assign cy[0]  = carry_q;

  for (genvar k = 0; k < SLICES; k++) begin : g_slice
    logic [PARCEL_W-1:0] below_hi;
    slot_t               s_lo;
    slot_t               s_hi;

    if (k == 0) begin : g_first
      assign below_hi = hi_q;
    end else begin : g_rest
      assign below_hi = grp_data_i[WORD_W*(k-1)+PARCEL_W +: PARCEL_W];
    end

    mixlen_slice u_slice (
      .en        (accept),
      .carry_in  (cy[k]),
      .prev_hi   (below_hi),
      .chunk     (grp_data_i[WORD_W*k +: WORD_W]),
      .slot_lo   (s_lo),
      .slot_hi   (s_hi),
      .carry_out (cy[k+1])
    );

    assign slot_valid_o[2*k]                  = s_lo.vld;
    assign slot_valid_o[2*k+1]                = s_hi.vld;
    assign slot_is32_o[2*k]                   = s_lo.is32;
    assign slot_is32_o[2*k+1]                 = s_hi.is32;
    assign slot_insn_o[WORD_W*(2*k)   +: WORD_W] = s_lo.insn;
    assign slot_insn_o[WORD_W*(2*k+1) +: WORD_W] = s_hi.insn;
  end

  mixlen_carry_reg u_carry (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept),
    .flush   (flush_i),
    .carry_d (cy[SLICES]),
    .hi_d    (grp_data_i[GRP_W-1 -: PARCEL_W]),
    .carry_q (carry_q),
    .hi_q    (hi_q)
  );

endmodule

// File: rtl/mixlen_checks.sv
module mixlen_checks #(
  parameter int SLICES = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 grp_valid_i,
  input logic                 flush_i,
  input logic [2*SLICES-1:0]  slot_valid_o,
  input logic [2*SLICES-1:0]  slot_is32_o,
  input logic [64*SLICES-1:0] slot_insn_o,
  input logic                 carry_q,
  input logic [15:0]          hi_q
);

  a_r7_idle_no_slots: assert property (@(posedge clk) disable iff (!rst_n)
    !grp_valid_i |-> slot_valid_o == '0);

  a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!grp_valid_i && !flush_i) |=> ($stable(carry_q) && $stable(hi_q)));

  a_r8_flush_no_slots: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |-> slot_valid_o == '0);

  a_r8_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !carry_q);

  a_r6_cross_group: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_valid_i && !flush_i && carry_q) |->
      (slot_valid_o[0] && slot_is32_o[0] && slot_insn_o[15:0] == hi_q));

  for (genvar j = 0; j < 2*SLICES; j++) begin : g_slot
    a_r1_size_flag: assert property (@(posedge clk) disable iff (!rst_n)
      slot_valid_o[j] |-> (slot_is32_o[j] == (slot_insn_o[32*j +: 2] == 2'b11)));
  end

  for (genvar k = 0; k < SLICES; k++) begin : g_pair
    a_r2_pair_order: assert property (@(posedge clk) disable iff (!rst_n)
      slot_valid_o[2*k+1] |-> (slot_valid_o[2*k] && !slot_is32_o[2*k+1]));
  end

endmodule

bind mixlen_splitter mixlen_checks #(.SLICES(SLICES)) u_checks (
  .clk          (clk),
  .rst_n        (rst_n),
  .grp_valid_i  (grp_valid_i),
  .flush_i      (flush_i),
  .slot_valid_o (slot_valid_o),
  .slot_is32_o  (slot_is32_o),
  .slot_insn_o  (slot_insn_o),
  .carry_q      (carry_q),
  .hi_q         (hi_q)
);

// File: tb/sim_mixlen_splitter.sv
module sim_mixlen_splitter;

  localparam int CLK_PERIOD = 10;
  localparam int SL   = 4;
  localparam int NV   = 12;

  typedef struct packed {
    logic         vld;
    logic         fl;
    logic [127:0] d;
    logic [7:0]   ev;
    logic [7:0]   e32;
    logic [31:0]  s0;
    logic [3:0]   req;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b0, 128'h4001_2002_4001_2002_4001_2002_4001_2002, 8'hFF, 8'h00, 32'h0000_2002, 4'd2},
    '{1'b1, 1'b0, 128'hABCD_0013_ABCD_0013_ABCD_0013_ABCD_0013, 8'h55, 8'h55, 32'hABCD_0013, 4'd3},
    '{1'b1, 1'b0, 128'h000B_7777_0003_9999_0002_5555_0007_0001, 8'h5D, 8'h44, 32'h0000_0001, 4'd4},
    '{1'b1, 1'b0, 128'h0001_0002_0001_0002_0001_0002_0001_CAFE, 8'hFF, 8'h01, 32'hCAFE_000B, 4'd6},
    '{1'b1, 1'b0, 128'h000F_0001_0001_0002_0001_0002_0001_0002, 8'h7F, 8'h00, 32'h0000_0002, 4'd6},
    '{1'b0, 1'b0, 128'h0,                                      8'h00, 8'h00, 32'h0,         4'd7},
    '{1'b1, 1'b1, 128'h0001_0002_0001_0002_0001_0002_0001_0002, 8'h00, 8'h00, 32'h0,         4'd8},
    '{1'b1, 1'b0, 128'h0001_0002_0001_0002_0001_0002_0001_0013, 8'hFD, 8'h01, 32'h0001_0013, 4'd8},
    '{1'b1, 1'b0, 128'h0003_0001_0001_0002_0001_0002_0001_0002, 8'h7F, 8'h00, 32'h0000_0002, 4'd6},
    '{1'b0, 1'b0, 128'h0,                                      8'h00, 8'h00, 32'h0,         4'd7},
    '{1'b1, 1'b0, 128'h0001_0002_0001_0002_0001_0002_0001_0042, 8'hFF, 8'h01, 32'h0042_0003, 4'd7},
    '{1'b1, 1'b0, 128'h0001_0002_0001_2222_0007_1111_0003_0001, 8'hF5, 8'h14, 32'h0000_0001, 4'd5}
  };

  logic          clk;
  logic          rst_n;
  logic          grp_valid_i;
  logic          flush_i;
  logic [127:0]  grp_data_i;
  logic [7:0]    slot_valid_o;
  logic [7:0]    slot_is32_o;
  logic [255:0]  slot_insn_o;

  int checks;
  int errors;
  int cycles;
  bit done;

  mixlen_splitter #(.SLICES(SL)) u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .grp_valid_i  (grp_valid_i),
    .flush_i      (flush_i),
    .grp_data_i   (grp_data_i),
    .slot_valid_o (slot_valid_o),
    .slot_is32_o  (slot_is32_o),
    .slot_insn_o  (slot_insn_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic string req_name(input logic [3:0] r);
    case (r)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check32(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // R1: each valid slot's size flag agrees with its low bits, and 16-bit slots are zero-extended
  task automatic check_r1_slots();
    logic [31:0] bad;
    bad = '0;
    for (int j = 0; j < 2*SL; j++) begin
      if (slot_valid_o[j]) begin
        if (slot_is32_o[j] !== (slot_insn_o[32*j +: 2] == 2'b11)) bad[j] = 1'b1;
        if (!slot_is32_o[j] && slot_insn_o[32*j+16 +: 16] != 16'h0) bad[j] = 1'b1;
      end
    end
    check32("R1", "slots with bad size or extension", bad, 32'h0);
  endtask

  // drive at the falling edge, sample a quarter period later, before the rising edge
  task automatic apply(input logic v, input logic f, input logic [127:0] d);
    @(negedge clk);
    grp_valid_i = v;
    flush_i     = f;
    grp_data_i  = d;
    #(CLK_PERIOD/4);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    checks = 0; errors = 0; cycles = 0; done = 1'b0;
    rst_n = 1'b0;
    grp_valid_i = 1'b0;
    flush_i = 1'b0;
    grp_data_i = '0;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    // R9: during reset, an idle input gives no slots
    check32("R9", "slot_valid in reset", {24'h0, slot_valid_o}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // R9: first group after reset sees no pending parcel
    apply(1'b1, 1'b0, 128'h0001_0002_0001_0002_0001_0002_0001_0013);
    check32("R9", "slot0 after reset", slot_insn_o[31:0], 32'h0001_0013);
    check32("R9", "slot_valid after reset", {24'h0, slot_valid_o}, 32'h0000_00FD);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i].vld, VEC[i].fl, VEC[i].d);
      check32(req_name(VEC[i].req), $sformatf("vec %0d slot_valid", i), {24'h0, slot_valid_o}, {24'h0, VEC[i].ev});
      check32(req_name(VEC[i].req), $sformatf("vec %0d slot_is32", i), {24'h0, slot_is32_o & slot_valid_o}, {24'h0, VEC[i].e32});
      if (VEC[i].ev[0]) check32(req_name(VEC[i].req), $sformatf("vec %0d slot0", i), slot_insn_o[31:0], VEC[i].s0);
      check_r1_slots();
    end

    // R4, R5: inner slots of the last vector
    check32("R4", "slot4 misaligned word", slot_insn_o[4*32 +: 32], 32'h2222_0007);
    check32("R5", "slot2 misaligned word", slot_insn_o[2*32 +: 32], 32'h1111_0003);
    check32("R2", "slot5 upper parcel", slot_insn_o[5*32 +: 32], 32'h0000_0001);

    // R9: reset while a parcel is pending drops it
    apply(1'b1, 1'b0, 128'h000F_0001_0001_0002_0001_0002_0001_0002);
    @(negedge clk);
    grp_valid_i = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    apply(1'b1, 1'b0, 128'h0001_0002_0001_0002_0001_0002_0001_0013);
    check32("R9", "slot0 after mid-run reset", slot_insn_o[31:0], 32'h0001_0013);
    check32("R9", "slot_valid after mid-run reset", {24'h0, slot_valid_o}, 32'h0000_00FD);

    // R8: flush with valid low still clears a pending parcel
    apply(1'b1, 1'b0, 128'h000F_0001_0001_0002_0001_0002_0001_0002);
    apply(1'b0, 1'b1, 128'h0);
    check32("R8", "slot_valid during flush", {24'h0, slot_valid_o}, 32'h0);
    apply(1'b1, 1'b0, 128'h0001_0002_0001_0002_0001_0002_0001_0013);
    check32("R8", "slot0 after flush", slot_insn_o[31:0], 32'h0001_0013);

    @(negedge clk);
    grp_valid_i = 1'b0;
    done = 1'b1;
    finish_run();
  end

endmodule